// File: doc/BRIEF.md
# NAND program command sequencer

This block decodes the command, address and data bytes that a host writes into an asynchronous x8 NAND flash device, for the page-program family only. Each byte arrives already latched, with a strobe that marks it as a command, address or data cycle. The block opens a program sequence, collects the column and row address cycles, and keeps a column pointer into the on-chip page register. Each data byte is written at the pointer and the pointer then advances. The host can move the pointer in the middle of a sequence with the random data input command (85h). Data can therefore land in non-contiguous columns before the sequence is confirmed.

A confirm byte ends the sequence. The block then emits a one-cycle program-start pulse and a program-mode code, and starts the busy timing on its two ready flags. One flag is for the host interface and one is for the array. The address-to-data delay is modelled as a number of clock cycles, during which data bytes are refused. The flash array itself, error correction and electrical pin timing are not part of the block.

Top module: `nand_prog_seq`

## Requirements
- R1: A command 80h taken while `rdy`=1 opens a page-program sequence. It takes two column address cycles (the first is the low byte, the second is the high byte of a 16-bit column) and then three row address cycles. The column pointer is loaded with that column, and `data_mode` rises after the last row cycle.
- R2: After the last address cycle of an opener or of a pointer reload, data bytes are refused for TADL_CYC cycles. A data byte in the k-th cycle after that address cycle is accepted only when k > TADL_CYC.
- R3: An accepted data byte gives `pg_we`=1 in the next cycle, with `pg_wdata` equal to the byte and `pg_addr` equal to the pointer. The pointer then increases by one, so consecutive writes go to consecutive columns.
- R4: Inside an open sequence (`data_mode`=1), command 85h followed by two column cycles reloads the pointer and re-arms the R2 delay. Data then resumes at the new column. Supplying data after the reload is optional.
- R5: A command 85h taken in idle while `rdy`=1 opens an internal-move sequence. It uses the same two column and three row cycles as R1.
- R6: In data mode, the confirm bytes 10h, 11h and 15h each end the sequence. One cycle later `pgm_start` pulses for exactly one cycle. `pgm_mode` is 0 for 10h after an 80h opener, 1 for 10h after an 85h opener, 2 for 15h and 3 for 11h.
- R7: A pointer value of 2112 (PAGE_BYTES) or more, whether loaded or reached by advancing, makes data bytes have no write effect until the pointer is reloaded.
- R8: A command byte other than 85h, 10h, 11h or 15h in data mode, or any command byte during an address phase, returns the block to idle with no `pgm_start`.
- R9: After a 10h or 11h confirm, `rdy` and `ardy` both go low in the cycle of `pgm_start` and stay low for BUSY_CYC cycles.
- R10: After a 15h confirm, `rdy` is low for CACHE_CYC cycles and `ardy` is low for BUSY_CYC cycles. A new sequence is accepted while `rdy`=1 and `ardy`=0.
- R11: While `rdy`=0 an opener command is ignored. Address and data bytes in idle have no effect.
- R12: After reset, `rdy`=1, `ardy`=1, `data_mode`=0, `pg_we`=0 and `pgm_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | `bus_byte` is a command cycle |
| addr_valid | input | 1 | `bus_byte` is an address cycle |
| data_valid | input | 1 | `bus_byte` is a data input cycle |
| bus_byte | input | 8 | Latched host byte |
| pg_we | output | 1 | Page register write strobe |
| pg_addr | output | ADDR_W (12) | Page register write column |
| pg_wdata | output | 8 | Page register write data |
| data_mode | output | 1 | Data input mode is active |
| pgm_start | output | 1 | One-cycle program-start pulse |
| pgm_mode | output | 2 | Program kind that goes with `pgm_start` |
| rdy | output | 1 | Host interface ready |
| ardy | output | 1 | Array ready |

## Verification
The assertions check four properties on every cycle:
- A write never targets a column at or beyond the page size.
- Back-to-back writes hit adjacent columns.
- No write appears outside data mode.
- The start pulse lasts one cycle, follows data mode and coincides with the array being busy, and the interface is never busy while the array is ready.

The refused-data window, the pointer reload landing at the new column, the program-mode codes, the busy durations and the ignoring of commands while busy depend on the order of the host bytes. These can only be shown by the bench's sequences.

// File: rtl/nps_pkg.sv
// Package: command codes, sequencer states and program-mode encoding
// shared by the NAND program sequencer modules.
package nps_pkg;
    localparam logic [7:0] OP_PROG   = 8'h80;
    localparam logic [7:0] OP_RAND   = 8'h85;
    localparam logic [7:0] OP_CONF   = 8'h10;
    localparam logic [7:0] OP_PLANE  = 8'h11;
    localparam logic [7:0] OP_CACHE  = 8'h15;
    localparam int         BYTE_W    = 8;
    localparam int         PTR_W     = 2 * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE, ST_COL0, ST_COL1, ST_ROW0, ST_ROW1, ST_ROW2,
        ST_DATA, ST_RCOL0, ST_RCOL1
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_PAGE  = 2'd0,
        MODE_MOVE  = 2'd1,
        MODE_CACHE = 2'd2,
        MODE_PLANE = 2'd3
    } prog_mode_e;
endpackage

// File: rtl/nps_seq_fsm.sv
// Sequence decoder. It walks the opener, address, data and confirm
// phases and emits pointer loads, delay arming, busy kicks and the
// program-start pulse.
// Assumes the host presents at most one strobe per cycle.
module nps_seq_fsm
    import nps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 addr_valid,
    input  logic [BYTE_W-1:0]    bus_byte,
    input  logic                 rdy,
    output logic                 col_load,
    output logic [PTR_W-1:0]     col_value,
    output logic                 adl_start,
    output logic                 data_mode,
    output logic                 kick_full,
    output logic                 kick_cache,
    output logic                 pgm_start,
    output prog_mode_e           pgm_mode
);
    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] col_lo_q;
    logic              lo_cap;
    logic              move_q, move_d;
    logic              start_d;
    prog_mode_e        mode_d;

    assign data_mode = (state_q == ST_DATA);
    assign col_value = {bus_byte, col_lo_q};

    // Next-state and strobe decode for every host byte.
    always_comb begin
        state_d    = state_q;
        move_d     = move_q;
        lo_cap     = 1'b0;
        col_load   = 1'b0;
        adl_start  = 1'b0;
        kick_full  = 1'b0;
        kick_cache = 1'b0;
        start_d    = 1'b0;
        mode_d     = pgm_mode;
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid && rdy && (bus_byte == OP_PROG || bus_byte == OP_RAND)) begin
                    state_d = ST_COL0;
                    move_d  = (bus_byte == OP_RAND);
                end
            end
            ST_COL0, ST_RCOL0: begin
                if (cmd_valid) begin
                    state_d = ST_IDLE;
                end else if (addr_valid) begin
                    lo_cap  = 1'b1;
                    state_d = (state_q == ST_COL0) ? ST_COL1 : ST_RCOL1;
                end
            end
            ST_COL1: begin
                if (cmd_valid) begin
                    state_d = ST_IDLE;
                end else if (addr_valid) begin
                    col_load = 1'b1;
                    state_d  = ST_ROW0;
                end
            end
            ST_ROW0, ST_ROW1: begin
                if (cmd_valid) begin
                    state_d = ST_IDLE;
                end else if (addr_valid) begin
                    state_d = (state_q == ST_ROW0) ? ST_ROW1 : ST_ROW2;
                end
            end
            ST_ROW2: begin
                if (cmd_valid) begin
                    state_d = ST_IDLE;
                end else if (addr_valid) begin
                    adl_start = 1'b1;
                    state_d   = ST_DATA;
                end
            end
            ST_RCOL1: begin
                if (cmd_valid) begin
                    state_d = ST_IDLE;
                end else if (addr_valid) begin
                    col_load  = 1'b1;
                    adl_start = 1'b1;
                    state_d   = ST_DATA;
                end
            end
            ST_DATA: begin
                if (cmd_valid) begin
                    state_d = ST_IDLE;
                    case (bus_byte)
                        OP_RAND:  state_d = ST_RCOL0;
                        OP_CONF: begin
                            start_d   = 1'b1;
                            kick_full = 1'b1;
                            mode_d    = move_q ? MODE_MOVE : MODE_PAGE;
                        end
                        OP_PLANE: begin
                            start_d   = 1'b1;
                            kick_full = 1'b1;
                            mode_d    = MODE_PLANE;
                        end
                        OP_CACHE: begin
                            start_d    = 1'b1;
                            kick_cache = 1'b1;
                            mode_d     = MODE_CACHE;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, low column byte, opener kind and start pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            col_lo_q  <= '0;
            move_q    <= 1'b0;
            pgm_start <= 1'b0;
            pgm_mode  <= MODE_PAGE;
        end else begin
            state_q   <= state_d;
            move_q    <= move_d;
            pgm_start <= start_d;
            pgm_mode  <= mode_d;
            if (lo_cap) col_lo_q <= bus_byte;
        end
    end

    // R6: a start pulse only ever follows a cycle in data mode.
    a_r6_start_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |-> $past(data_mode));
    // R8: an unsupported command in data mode leaves data mode.
    a_r8_abort_leaves_data: assert property (@(posedge clk) disable iff (!rst_n)
        (data_mode && cmd_valid && bus_byte != OP_RAND && bus_byte != OP_CONF
         && bus_byte != OP_PLANE && bus_byte != OP_CACHE) |=> !data_mode && !pgm_start);
endmodule

// File: rtl/nps_col_ptr.sv
// Column pointer and address-to-data delay. It loads the pointer,
// refuses data while the delay counts down or the pointer is past the
// page, and writes accepted bytes to the page register.
// Assumes TADL_CYC >= 1.
module nps_col_ptr
    import nps_pkg::*;
#(
    parameter int PAGE_BYTES = 2112,
    parameter int TADL_CYC   = 3,
    localparam int ADDR_W    = $clog2(PAGE_BYTES),
    localparam int AW        = $clog2(TADL_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               col_load,
    input  logic [PTR_W-1:0]   col_value,
    input  logic               adl_start,
    input  logic               data_mode,
    input  logic               data_valid,
    input  logic [BYTE_W-1:0]  bus_byte,
    output logic               pg_we,
    output logic [ADDR_W-1:0]  pg_addr,
    output logic [BYTE_W-1:0]  pg_wdata
);
    localparam logic [PTR_W-1:0] PAGE_END = PTR_W'(PAGE_BYTES);

    logic [PTR_W-1:0] ptr_q;
    logic [AW-1:0]    adl_q;
    logic             accept;

    assign accept = data_valid && data_mode && (adl_q == '0) && (ptr_q < PAGE_END);

    // Delay counter: armed on the last address cycle, counts to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          adl_q <= '0;
        else if (adl_start)  adl_q <= AW'(TADL_CYC);
        else if (adl_q != 0) adl_q <= adl_q - 1'b1;
    end

    // Pointer load/advance and page register write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            pg_we    <= 1'b0;
            pg_addr  <= '0;
            pg_wdata <= '0;
        end else begin
            pg_we <= accept;
            if (col_load)    ptr_q <= col_value;
            else if (accept) ptr_q <= ptr_q + 1'b1;
            if (accept) begin
                pg_addr  <= ptr_q[ADDR_W-1:0];
                pg_wdata <= bus_byte;
            end
        end
    end

    // R7: writes stay inside the page.
    a_r7_we_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> (int'(pg_addr) < PAGE_BYTES));
    // R3: back-to-back writes hit adjacent columns.
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_we && $past(pg_we)) |-> pg_addr == $past(pg_addr) + ADDR_W'(1));
endmodule

// File: rtl/nps_busy.sv
// Ready timing. A full confirm holds both flags low for BUSY_CYC cycles.
// A cache confirm holds the interface flag low for CACHE_CYC cycles and
// the array flag low for BUSY_CYC cycles.
// Assumes 1 <= CACHE_CYC <= BUSY_CYC.
module nps_busy #(
    parameter int BUSY_CYC  = 20,
    parameter int CACHE_CYC = 2,
    localparam int BW       = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_full,
    input  logic kick_cache,
    output logic rdy,
    output logic ardy
);
    logic [BW-1:0] rdy_cnt_q, ardy_cnt_q;

    assign rdy  = (rdy_cnt_q == '0);
    assign ardy = (ardy_cnt_q == '0);

    // Busy counters: reloaded by a confirm, count down to ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_cnt_q  <= '0;
            ardy_cnt_q <= '0;
        end else begin
            if (kick_full)           rdy_cnt_q <= BW'(BUSY_CYC);
            else if (kick_cache)     rdy_cnt_q <= BW'(CACHE_CYC);
            else if (rdy_cnt_q != 0) rdy_cnt_q <= rdy_cnt_q - 1'b1;
            if (kick_full || kick_cache) ardy_cnt_q <= BW'(BUSY_CYC);
            else if (ardy_cnt_q != 0)    ardy_cnt_q <= ardy_cnt_q - 1'b1;
        end
    end

    // R10: the interface is never busy while the array is ready.
    a_r10_rdy_within_ardy: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !ardy);
endmodule

// File: rtl/nand_prog_seq.sv
// Top of the NAND program command sequencer. It joins the sequence
// decoder, the column pointer with its data delay, and the ready timing.
// Assumes one host strobe per cycle and that host bytes are already latched.
module nand_prog_seq #(
    parameter int PAGE_BYTES = 2112,
    parameter int TADL_CYC   = 3,
    parameter int BUSY_CYC   = 20,
    parameter int CACHE_CYC  = 2,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              addr_valid,
    input  logic              data_valid,
    input  logic [7:0]        bus_byte,
    output logic              pg_we,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [7:0]        pg_wdata,
    output logic              data_mode,
    output logic              pgm_start,
    output logic [1:0]        pgm_mode,
    output logic              rdy,
    output logic              ardy
);
    import nps_pkg::*;

    logic             col_load, adl_start, kick_full, kick_cache;
    logic [PTR_W-1:0] col_value;
    prog_mode_e       mode_w;

    assign pgm_mode = mode_w;

    nps_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr_valid(addr_valid),
        .bus_byte(bus_byte), .rdy(rdy), .col_load(col_load), .col_value(col_value),
        .adl_start(adl_start), .data_mode(data_mode), .kick_full(kick_full),
        .kick_cache(kick_cache), .pgm_start(pgm_start), .pgm_mode(mode_w)
    );

    nps_col_ptr #(.PAGE_BYTES(PAGE_BYTES), .TADL_CYC(TADL_CYC)) u_ptr (
        .clk(clk), .rst_n(rst_n), .col_load(col_load), .col_value(col_value),
        .adl_start(adl_start), .data_mode(data_mode), .data_valid(data_valid),
        .bus_byte(bus_byte), .pg_we(pg_we), .pg_addr(pg_addr), .pg_wdata(pg_wdata)
    );

    nps_busy #(.BUSY_CYC(BUSY_CYC), .CACHE_CYC(CACHE_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .kick_full(kick_full), .kick_cache(kick_cache),
        .rdy(rdy), .ardy(ardy)
    );

    // R6: the start pulse lasts a single cycle.
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !pgm_start);
    // R9: the array is busy in the cycle the start pulse appears.
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |-> !ardy);
    // R11: no page write follows a cycle outside data mode.
    a_r11_quiet_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
        !data_mode |=> !pg_we);
endmodule

// File: tb/nand_prog_seq_tb_top.sv
`timescale 1ns/1ps
module nand_prog_seq_tb_top;
    localparam int PAGE_BYTES = 2112;
    localparam int TADL_CYC   = 3;
    localparam int BUSY_CYC   = 20;
    localparam int CACHE_CYC  = 2;
    localparam logic [1:0] K_IDLE = 2'd0, K_CMD = 2'd1, K_ADDR = 2'd2, K_DATA = 2'd3;
    localparam int NV = 20;
    // {kind, byte, exp_we, exp_start, exp_addr}
    localparam logic [23:0] VEC [NV] = '{
        {K_CMD,  8'h80, 1'b0, 1'b0, 12'h000},  // R1 opener
        {K_ADDR, 8'h05, 1'b0, 1'b0, 12'h000},
        {K_ADDR, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_ADDR, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_ADDR, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_ADDR, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_DATA, 8'hA1, 1'b0, 1'b0, 12'h000},  // R2 k=1 refused
        {K_IDLE, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_IDLE, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_DATA, 8'hB2, 1'b1, 1'b0, 12'h005},  // R2 k=4 accepted, R1 column
        {K_DATA, 8'hC3, 1'b1, 1'b0, 12'h006},  // R3 advance
        {K_CMD,  8'h85, 1'b0, 1'b0, 12'h000},  // R4 reload
        {K_ADDR, 8'h10, 1'b0, 1'b0, 12'h000},
        {K_ADDR, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_IDLE, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_IDLE, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_IDLE, 8'h00, 1'b0, 1'b0, 12'h000},
        {K_DATA, 8'hD4, 1'b1, 1'b0, 12'h010},  // R4 new column
        {K_DATA, 8'hE5, 1'b1, 1'b0, 12'h011},
        {K_CMD,  8'h10, 1'b0, 1'b1, 12'h000}   // R6 confirm
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, addr_valid = 1'b0, data_valid = 1'b0;
    logic [7:0] bus_byte = '0;
    logic pg_we, data_mode, pgm_start, rdy, ardy;
    logic [11:0] pg_addr;
    logic [7:0] pg_wdata;
    logic [1:0] pgm_mode;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    nand_prog_seq #(.PAGE_BYTES(PAGE_BYTES), .TADL_CYC(TADL_CYC),
                    .BUSY_CYC(BUSY_CYC), .CACHE_CYC(CACHE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .addr_valid(addr_valid),
        .data_valid(data_valid), .bus_byte(bus_byte), .pg_we(pg_we), .pg_addr(pg_addr),
        .pg_wdata(pg_wdata), .data_mode(data_mode), .pgm_start(pgm_start),
        .pgm_mode(pgm_mode), .rdy(rdy), .ardy(ardy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One host cycle; outputs are valid to sample when it returns.
    task automatic step(input logic [1:0] kind, input logic [7:0] b);
        @(negedge clk);
        cmd_valid  = (kind == K_CMD);
        addr_valid = (kind == K_ADDR);
        data_valid = (kind == K_DATA);
        bus_byte   = b;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; addr_valid = 1'b0; data_valid = 1'b0;
    endtask

    task automatic open_seq(input logic [7:0] op, input logic [15:0] col);
        step(K_CMD, op);
        step(K_ADDR, col[7:0]);
        step(K_ADDR, col[15:8]);
        repeat (3) step(K_ADDR, 8'h00);
        repeat (TADL_CYC) step(K_IDLE, 8'h00);
    endtask

    task automatic reload(input logic [15:0] col);
        step(K_CMD, 8'h85);
        step(K_ADDR, col[7:0]);
        step(K_ADDR, col[15:8]);
        repeat (TADL_CYC) step(K_IDLE, 8'h00);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200; i++) begin
            if (rdy && ardy) break;
            step(K_IDLE, 8'h00);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R12 reset state
        chk("R12", "rdy", rdy, 1);
        chk("R12", "ardy", ardy, 1);
        chk("R12", "data_mode", data_mode, 0);
        chk("R12", "pg_we", pg_we, 0);
        chk("R12", "pgm_start", pgm_start, 0);

        // R11 address and data in idle have no effect
        step(K_ADDR, 8'h12);
        step(K_DATA, 8'h34);
        chk("R11", "idle pg_we", pg_we, 0);
        chk("R11", "idle data_mode", data_mode, 0);

        // Vector table: R1..R6
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            step(v[23:22], v[21:14]);
            chk("R3", $sformatf("vec%0d pg_we", i), pg_we, v[13]);
            chk("R6", $sformatf("vec%0d pgm_start", i), pgm_start, v[12]);
            if (v[13]) begin
                chk("R3", $sformatf("vec%0d pg_addr", i), pg_addr, v[11:0]);
                chk("R3", $sformatf("vec%0d pg_wdata", i), pg_wdata, v[21:14]);
            end
        end
        chk("R6", "mode page", pgm_mode, 0);
        chk("R9", "rdy after 10h", rdy, 0);
        chk("R9", "ardy after 10h", ardy, 0);
        step(K_IDLE, 8'h00);
        chk("R6", "pulse ends", pgm_start, 0);

        // R11 opener ignored while busy
        step(K_CMD, 8'h80);
        repeat (5) step(K_ADDR, 8'h00);
        chk("R11", "busy opener data_mode", data_mode, 0);
        step(K_DATA, 8'h55);
        chk("R11", "busy opener pg_we", pg_we, 0);
        wait_ready();

        // R9 precise busy with 11h; R6 mode 3
        open_seq(8'h80, 16'h0000);
        step(K_CMD, 8'h11);
        chk("R6", "11h start", pgm_start, 1);
        chk("R6", "mode plane", pgm_mode, 3);
        chk("R9", "rdy low", rdy, 0);
        repeat (BUSY_CYC - 1) step(K_IDLE, 8'h00);
        chk("R9", "rdy still low", rdy, 0);
        chk("R9", "ardy still low", ardy, 0);
        step(K_IDLE, 8'h00);
        chk("R9", "rdy back", rdy, 1);
        chk("R9", "ardy back", ardy, 1);

        // R5 internal move opener, mode 1
        open_seq(8'h85, 16'h0020);
        step(K_DATA, 8'h77);
        chk("R5", "move pg_we", pg_we, 1);
        chk("R5", "move pg_addr", pg_addr, 12'h020);
        step(K_CMD, 8'h10);
        chk("R5", "mode move", pgm_mode, 1);
        wait_ready();

        // R10 cache program timing
        open_seq(8'h80, 16'h0000);
        step(K_CMD, 8'h15);
        chk("R10", "mode cache", pgm_mode, 2);
        chk("R10", "rdy low", rdy, 0);
        repeat (CACHE_CYC - 1) step(K_IDLE, 8'h00);
        chk("R10", "rdy still low", rdy, 0);
        step(K_IDLE, 8'h00);
        chk("R10", "rdy back", rdy, 1);
        chk("R10", "ardy still low", ardy, 0);
        open_seq(8'h80, 16'h0007);
        step(K_DATA, 8'h99);
        chk("R10", "ardy low during new seq", ardy, 0);
        chk("R10", "write while array busy", pg_we, 1);
        chk("R10", "addr while array busy", pg_addr, 12'h007);

        // R8 unsupported command aborts
        step(K_CMD, 8'h31);
        chk("R8", "abort data_mode", data_mode, 0);
        step(K_DATA, 8'h42);
        chk("R8", "abort pg_we", pg_we, 0);
        step(K_CMD, 8'h10);
        chk("R8", "no start after abort", pgm_start, 0);
        wait_ready();

        // R7 page end
        open_seq(8'h80, 16'h083F);
        step(K_DATA, 8'h01);
        chk("R7", "last column write", pg_we, 1);
        chk("R7", "last column addr", pg_addr, 12'h83F);
        step(K_DATA, 8'h02);
        chk("R7", "past end ignored", pg_we, 0);
        reload(16'h0840);
        step(K_DATA, 8'h03);
        chk("R7", "loaded 2112 ignored", pg_we, 0);
        reload(16'h0003);
        step(K_DATA, 8'h04);
        chk("R7", "reload recovers", pg_we, 1);
        chk("R4", "reload addr", pg_addr, 12'h003);
        // R4 reload with no data, then confirm
        step(K_CMD, 8'h85);
        step(K_ADDR, 8'h09);
        step(K_ADDR, 8'h00);
        step(K_CMD, 8'h10);
        chk("R4", "confirm after empty reload", pgm_start, 1);
        chk("R6", "mode page again", pgm_mode, 0);
        wait_ready();

        // R8 command during address phase aborts
        step(K_CMD, 8'h80);
        step(K_ADDR, 8'h00);
        step(K_CMD, 8'h80);
        repeat (4) step(K_ADDR, 8'h00);
        chk("R8", "addr-phase abort", data_mode, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule